// File: doc/BRIEF.md
# Oscillation Count Mean Estimator

This block measures how many transient oscillations a stimulated loop produces, averaged over a long series of stimulation intervals. It generates its own periodic stimulation signal. Each period forms one measurement interval. During an interval, rising edges of the loop output are counted in a narrow saturating counter. When the interval ends, that count is added into a wide accumulator. After a power-of-two number of intervals, the total is shifted right to give the mean count. The run then stops and signals completion with a one-cycle pulse.

The loop output is asynchronous to the system clock. It is brought in through a two-flop synchronizer, and edges are detected in the clock domain. The low three bits of the live per-interval count are also exposed directly. They carry the noisy part of the measurement, for use as raw random bits. The mean reflects the stable, device-dependent part. A software-free start pulse begins a run and may also abort one that is in progress. With the default parameters the counter is 8 bits wide, there are 2^18 intervals, and the accumulator is 26 bits wide.

Top module: `osc_mean_est`

## Requirements
- R1: While a run is active, `stim_o` is high for phases 0 to HIGH-1 of each PERIOD-cycle interval and low for the remaining phases. It is low whenever no run is active.
- R2: Rising edges of `loop_in` are counted after a two-flop synchronizer. The count of an interval starts from zero at that interval's phase 0, so counts from earlier intervals do not carry over.
- R3: The per-interval count saturates at 2^CNT_W-1 instead of wrapping.
- R4: `noise_o` equals bits [2:0] of the current interval's count.
- R5: After 2^LOG_RUNS intervals, `mean_o` becomes floor(sum of the interval counts / 2^LOG_RUNS). The run then ends and stimulation stops.
- R6: `done_o` is high for exactly one cycle, the cycle in which the new `mean_o` first appears.
- R7: `mean_o` keeps its value between completions, including throughout a following run.
- R8: A `start` pulse, even in the middle of a run, clears the accumulator, the interval count and the counter, and begins a new run at phase 0. An aborted run contributes nothing to the next mean.
- R9: After reset, `mean_o`, `done_o`, `stim_o` and `noise_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins, or restarts, an averaging run |
| loop_in | input | 1 | Asynchronous output of the oscillating loop |
| stim_o | output | 1 | Periodic stimulation signal for the loop |
| mean_o | output | CNT_W | Mean oscillation count of the last completed run |
| done_o | output | 1 | One-cycle pulse when `mean_o` is updated |
| noise_o | output | 3 | Low three bits of the live interval count |

## Verification
The bench builds the block with CNT_W=4, LOG_RUNS=2, PERIOD=96 and HIGH=40. With these values a complete run takes only four intervals, so the bench can sweep every per-interval count from zero to past the saturation value of 15. It can also check floor rounding with uneven sums. The 96-cycle period leaves room for more than twenty loop pulses per interval, which drives the counter well into saturation. It also leaves room to abort a run mid-way and confirm that none of the aborted run's counts leak into the next mean.

// File: rtl/osc_mean_est.sv
module osc_mean_est #(
  parameter int CNT_W    = 8,
  parameter int LOG_RUNS = 18,
  parameter int PERIOD   = 64,
  parameter int HIGH     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             loop_in,
  output logic             stim_o,
  output logic [CNT_W-1:0] mean_o,
  output logic             done_o,
  output logic [2:0]       noise_o
);
  localparam int ACC_W = CNT_W + LOG_RUNS;
  localparam int PH_W  = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [PH_W-1:0]  PH_LAST = PH_W'(PERIOD - 1);
  localparam logic [PH_W:0]    HIGH_V  = (PH_W + 1)'(HIGH);

  logic [2:0]          sync_q;
  logic                running;
  logic [PH_W-1:0]     ph;
  logic [LOG_RUNS-1:0] runs;
  logic [CNT_W-1:0]    cnt, cnt_in;
  logic [ACC_W-1:0]    acc, acc_sum;
  logic                edge_w, ivl_end;

  assign edge_w  = sync_q[1] & ~sync_q[2];
  assign ivl_end = (ph == PH_LAST);
  assign cnt_in  = (edge_w && cnt != CNT_MAX) ? cnt + 1'b1 : cnt;
  assign acc_sum = acc + ACC_W'(cnt_in);
  assign stim_o  = running && ({1'b0, ph} < HIGH_V);
  assign noise_o = cnt[2:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], loop_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      ph      <= '0;
      runs    <= '0;
      cnt     <= '0;
      acc     <= '0;
      mean_o  <= '0;
      done_o  <= 1'b0;
    end else if (start) begin
      running <= 1'b1;
      ph      <= '0;
      runs    <= '0;
      cnt     <= '0;
      acc     <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (running) begin
        ph  <= ivl_end ? '0 : ph + 1'b1;
        cnt <= (ph == '0) ? CNT_W'(edge_w) : cnt_in;
        if (ivl_end) begin
          runs <= runs + 1'b1;
          if (runs == '1) begin
            mean_o  <= acc_sum[ACC_W-1:LOG_RUNS];
            done_o  <= 1'b1;
            running <= 1'b0;
            acc     <= '0;
          end else begin
            acc <= acc_sum;
          end
        end
      end
    end
  end
endmodule

// File: rtl/osc_mean_est_chk.sv
module osc_mean_est_chk #(
  parameter int CNT_W = 8,
  parameter int ACC_W = 26,
  parameter int PH_W  = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             done_o,
  input logic [CNT_W-1:0] mean_o,
  input logic             stim_o,
  input logic             running,
  input logic             ivl_end,
  input logic [PH_W-1:0]  ph,
  input logic [CNT_W-1:0] cnt,
  input logic [ACC_W-1:0] acc
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7
  mean_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> $stable(mean_o));

  // R3
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !start && !ivl_end && ph != '0 && cnt == CNT_MAX) |=> (cnt == CNT_MAX));

  // R1
  stim_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !stim_o);

  // R8
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (running && ph == '0 && cnt == '0 && acc == '0));
endmodule

bind osc_mean_est osc_mean_est_chk #(.CNT_W(CNT_W), .ACC_W(ACC_W), .PH_W(PH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done_o(done_o), .mean_o(mean_o),
  .stim_o(stim_o), .running(running), .ivl_end(ivl_end), .ph(ph), .cnt(cnt), .acc(acc)
);

// File: tb/test_osc_mean_est.sv
module test_osc_mean_est;
  localparam int CW = 4, LR = 2, P = 96, H = 40;
  localparam int NR = 1 << LR, MAXC = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, start = 0, loop_in = 0;
  logic stim_o, done_o;
  logic [CW-1:0] mean_o;
  logic [2:0] noise_o;
  int tests = 0, fails = 0;
  bit wd = 0;

  osc_mean_est #(.CNT_W(CW), .LOG_RUNS(LR), .PERIOD(P), .HIGH(H)) i_osc_mean_est (
    .clk(clk), .rst_n(rst_n), .start(start), .loop_in(loop_in),
    .stim_o(stim_o), .mean_o(mean_o), .done_o(done_o), .noise_o(noise_o));

  always #4 clk = ~clk;

  task automatic chk(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int satc(int n);
    return (n > MAXC) ? MAXC : n;
  endfunction

  task automatic do_start;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  // one interval with n loop pulses; entered at the negedge of phase 0
  task automatic run_ivl(int n);
    for (int j = 0; j < P; j++) begin
      loop_in = (j >= 2) && ((j - 2) < 4 * n) && (((j - 2) % 4) < 2);
      if (j == 0 || j == H - 1 || j == H || j == P - 1)
        chk(stim_o == (j < H), "R1 stim phase", int'(stim_o), int'(j < H));
      if (j == P - 2)
        chk(noise_o == 3'(satc(n)), "R2 R4 live count bits", int'(noise_o), satc(n) % 8);
      @(negedge clk);
    end
    loop_in = 0;
  endtask

  task automatic run_avg(int a, int b, int c, int d, string tag);
    int ns[4];
    int sum;
    int exp;
    ns = '{a, b, c, d};
    sum = 0;
    do_start();
    for (int k = 0; k < NR; k++) begin
      run_ivl(ns[k]);
      sum += satc(ns[k]);
    end
    exp = sum >> LR;
    chk(done_o == 1'b1, "R6 done high", int'(done_o), 1);
    chk(mean_o == CW'(exp), tag, int'(mean_o), exp);
    @(negedge clk);
    chk(done_o == 1'b0, "R6 done single cycle", int'(done_o), 0);
    chk(mean_o == CW'(exp), "R7 mean holds", int'(mean_o), exp);
    chk(stim_o == 1'b0, "R5 stimulation stops", int'(stim_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    wd = 1;
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(mean_o == 0, "R9 reset mean", int'(mean_o), 0);
        chk(done_o == 0, "R9 reset done", int'(done_o), 0);
        chk(stim_o == 0, "R9 R1 reset stim", int'(stim_o), 0);
        chk(noise_o == 0, "R9 reset noise", int'(noise_o), 0);
        repeat (10) @(negedge clk);
        chk(stim_o == 0, "R1 idle stim", int'(stim_o), 0);

        for (int n = 0; n <= MAXC + 2; n++)
          run_avg(n, n, n, n, "R5 R3 uniform sweep mean");
        run_avg(1, 2, 3, 4, "R5 mixed mean");
        run_avg(3, 3, 3, 2, "R5 floor rounding");
        run_avg(7, 8, 9, 10, "R5 mixed mean 2");
        run_avg(20, 30, 16, 15, "R3 saturation mean");
        run_avg(12, 0, 0, 0, "R2 count cleared per interval");
        run_avg(0, 0, 0, 13, "R5 last interval counted");

        // mean held during a following run, then abort mid-run
        do_start();
        run_ivl(15);
        chk(mean_o == 3, "R7 mean held during run", int'(mean_o), 3);
        run_ivl(15);
        run_avg(1, 1, 1, 2, "R8 restart discards aborted run");
      end
      begin
        wait (wd);
      end
    join_any
    if (wd) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule